// File: doc/BRIEF.md
# Vector Loop Tail Predicate Generator

This block supplies the per-iteration lane predicate for a hardware vector loop over a 128-bit vector. Software loads the total number of elements and the element width, which is 8, 16 or 32 bits. The block then holds the count of elements that are still to be processed.

While more elements remain than fit in one vector, every lane is enabled. On the final pass, only the lowest lanes are enabled, up to the remaining count, so the loop body needs no separate scalar tail code. Each advance pulse removes one vector's worth of lanes from the remaining count. The count stops at zero.

The predicate has one bit per byte. All bytes of an active lane are set together. Two flags report the final iteration and loop completion.

Top module: `tail_pred_gen`

## Requirements
- R1: After reset the remaining count is zero, `mask_o` is 0, `done_o` is 1 and `last_o` is 0.
- R2: A cycle with `load_i` high stores `count_i` and `width_i`, and the outputs reflect them from the next cycle.
- R3: When `load_i` and `adv_i` are both high in the same cycle, the load wins and the advance is dropped.
- R4: The `width_i` code selects the lanes per vector: 2'b00 gives 8-bit elements and 16 lanes, 2'b01 gives 16-bit elements and 8 lanes, 2'b10 gives 32-bit elements and 4 lanes. Code 2'b11 is treated as 32-bit.
- R5: While the remaining count exceeds the lanes per vector, all 16 bits of `mask_o` are set.
- R6: While the remaining count is from 1 up to the lanes per vector, exactly the lowest remaining×(bytes per lane) bits of `mask_o` are set and all other bits are clear.
- R7: An advance without a load lowers the remaining count by the lanes per vector, and the count saturates at zero.
- R8: `last_o` is 1 exactly when the remaining count is nonzero and no greater than the lanes per vector.
- R9: With zero remaining, `mask_o` is 0 and `done_o` is 1. An advance at zero leaves the count at zero.
- R10: With neither load nor advance, the remaining count and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load new element count and width |
| count_i | input | CNT_W | Total element count to load |
| width_i | input | 2 | Element width code (00=8, 01=16, 10/11=32 bits) |
| adv_i | input | 1 | Iteration advance pulse |
| mask_o | output | VEC_BYTES | Byte-granular lane predicate for the current iteration |
| last_o | output | 1 | Current iteration is the final one |
| done_o | output | 1 | No elements remain |

## Verification
All three outputs are decoded combinationally from the registered count and width. A load or an advance sampled at one rising edge therefore shows on `mask_o`, `last_o` and `done_o` one cycle later, with no further delay.

The bench drives inputs on the falling edge and updates its reference model as the following rising edge will. At the next falling edge it compares all outputs against the model, before it drives the next stimulus. Every check therefore lands exactly one edge after its cause.

// File: rtl/tail_pred_pkg.sv
package tail_pred_pkg;
  typedef enum logic [1:0] {
    EW_8  = 2'b00,
    EW_16 = 2'b01,
    EW_32 = 2'b10,
    EW_32X = 2'b11
  } elem_w_e;
endpackage

// File: rtl/tail_lane_cfg.sv
module tail_lane_cfg #(
  parameter int VEC_BYTES = 16,
  localparam int LW = $clog2(VEC_BYTES + 1)
) (
  input  tail_pred_pkg::elem_w_e width_i,
  output logic [LW-1:0]          lanes_o,
  output logic [1:0]             shift_o
);
  import tail_pred_pkg::*;

  always_comb begin
    unique case (width_i)
      EW_8:    shift_o = 2'd0;
      EW_16:   shift_o = 2'd1;
      default: shift_o = 2'd2;
    endcase
    lanes_o = LW'(VEC_BYTES) >> shift_o;
  end
endmodule

// File: rtl/tail_remain_cnt.sv
module tail_remain_cnt #(
  parameter int CNT_W = 16,
  parameter int LW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             adv_i,
  input  logic [LW-1:0]    lanes_i,
  output logic [CNT_W-1:0] rem_o
);
  logic [CNT_W-1:0] rem_q, rem_d, lanes_ext;
  logic             over;

  assign lanes_ext = CNT_W'(lanes_i);
  assign over      = rem_q > lanes_ext;

  always_comb begin
    rem_d = rem_q;
    if (load_i)     rem_d = count_i;
    else if (adv_i) rem_d = over ? rem_q - lanes_ext : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else         rem_q <= rem_d;
  end

  assign rem_o = rem_q;

  a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rem_q == $past(count_i));
  a_r7_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && rem_q <= lanes_ext) |=> rem_q == '0);
  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && rem_q > lanes_ext) |=> rem_q == $past(rem_q) - $past(lanes_ext));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(rem_q));
endmodule

// File: rtl/tail_mask_gen.sv
module tail_mask_gen #(
  parameter int CNT_W     = 16,
  parameter int VEC_BYTES = 16,
  localparam int LW = $clog2(VEC_BYTES + 1)
) (
  input  logic [CNT_W-1:0]     rem_i,
  input  logic [LW-1:0]        lanes_i,
  input  logic [1:0]           shift_i,
  output logic [VEC_BYTES-1:0] mask_o
);
  logic [LW-1:0] act_lanes;
  logic [LW+1:0] act_bytes;

  assign act_lanes = (rem_i >= CNT_W'(lanes_i)) ? lanes_i : LW'(rem_i);
  assign act_bytes = (LW+2)'(act_lanes) << shift_i;

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    assign mask_o[b] = (LW+2)'(b) < act_bytes;
  end
endmodule

// File: rtl/tail_pred_gen.sv
module tail_pred_gen #(
  parameter int CNT_W     = 16,
  parameter int VEC_BYTES = 16,
  localparam int LW = $clog2(VEC_BYTES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CNT_W-1:0]     count_i,
  input  logic [1:0]           width_i,
  input  logic                 adv_i,
  output logic [VEC_BYTES-1:0] mask_o,
  output logic                 last_o,
  output logic                 done_o
);
  import tail_pred_pkg::*;

  elem_w_e          w_q;
  logic [LW-1:0]    lanes;
  logic [1:0]       shift;
  logic [CNT_W-1:0] rem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     w_q <= EW_8;
    else if (load_i) w_q <= elem_w_e'(width_i);
  end

  tail_lane_cfg #(.VEC_BYTES(VEC_BYTES)) u_cfg (
    .width_i(w_q), .lanes_o(lanes), .shift_o(shift)
  );

  tail_remain_cnt #(.CNT_W(CNT_W), .LW(LW)) u_cnt (
    .clk_i, .rst_ni, .load_i, .count_i, .adv_i,
    .lanes_i(lanes), .rem_o(rem)
  );

  tail_mask_gen #(.CNT_W(CNT_W), .VEC_BYTES(VEC_BYTES)) u_mask (
    .rem_i(rem), .lanes_i(lanes), .shift_i(shift), .mask_o(mask_o)
  );

  assign done_o = rem == '0;
  assign last_o = !done_o && rem <= CNT_W'(lanes);

  a_r9_done_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mask_o == '0);
  a_r5_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !last_o) |-> &mask_o);
  a_r6_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & (mask_o + 1'b1)) == '0);
  a_r8_last_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(last_o && done_o));
endmodule

// File: tb/tail_pred_gen_tb.sv
module tail_pred_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk_i = 0, rst_ni = 0, load_i = 0, adv_i = 0;
  logic [CNT_W-1:0] count_i = '0;
  logic [1:0] width_i = '0;
  logic [15:0] mask_o;
  logic last_o, done_o;

  int checks = 0, failures = 0;
  int m_rem = 0, m_w = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tail_pred_gen #(.CNT_W(CNT_W), .VEC_BYTES(16)) u_dut (
    .clk_i, .rst_ni, .load_i, .count_i, .width_i, .adv_i,
    .mask_o, .last_o, .done_o
  );

  function automatic int lanes_of(int w);
    return (w == 0) ? 16 : (w == 1) ? 8 : 4;
  endfunction

  function automatic logic [15:0] exp_mask(int rem, int w);
    int act = (rem > lanes_of(w)) ? lanes_of(w) : rem;
    int nb = act * (16 / lanes_of(w));
    logic [15:0] m = '0;
    for (int i = 0; i < 16; i++) if (i < nb) m[i] = 1'b1;
    return m;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    string mt = (m_rem == 0) ? "R9" : (m_rem > lanes_of(m_w)) ? "R5" : "R6";
    chk({tag, "/", mt}, "mask", int'(mask_o), int'(exp_mask(m_rem, m_w)));
    chk({tag, "/R8"}, "last", int'(last_o), int'(m_rem != 0 && m_rem <= lanes_of(m_w)));
    chk({tag, "/R9"}, "done", int'(done_o), int'(m_rem == 0));
  endtask

  // drive at negedge, model the next posedge, check at the following negedge
  task automatic cyc(bit ld, int cnt, int w, bit adv, string tag);
    load_i = ld; count_i = CNT_W'(cnt); width_i = 2'(w); adv_i = adv;
    if (ld) begin m_rem = cnt; m_w = w; end
    else if (adv) m_rem = (m_rem > lanes_of(m_w)) ? m_rem - lanes_of(m_w) : 0;
    @(negedge clk_i);
    load_i = 0; adv_i = 0;
    chk_all(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk_all("R1");
    rst_ni = 1;
    @(negedge clk_i);
    chk_all("R1");

    // R2 R5 R6 R7: 35 bytes of 8-bit data: 16,16,3
    cyc(1, 35, 0, 0, "R2");
    cyc(0, 0, 0, 1, "R7");
    cyc(0, 0, 0, 1, "R7");
    chk("R6", "mask3", int'(mask_o), 16'h0007);
    cyc(0, 0, 0, 1, "R7");
    cyc(0, 0, 0, 1, "R9");
    // R4: 16-bit, 5 elements -> 10 bytes
    cyc(1, 13, 1, 0, "R4");
    cyc(0, 0, 0, 1, "R4");
    chk("R4", "mask16b", int'(mask_o), 16'h03FF);
    // R4 code 3 -> 32-bit, 3 elements -> 12 bytes
    cyc(1, 3, 3, 0, "R4");
    chk("R4", "mask32b", int'(mask_o), 16'h0FFF);
    // R3: load and advance together
    cyc(1, 40, 2, 1, "R3");
    chk("R3", "notlast", int'(last_o), 0);
    // R10: hold
    cyc(0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, "R10");
    // R7 exact multiple: 8 x 32-bit -> 4,4,0
    cyc(1, 8, 2, 0, "R7");
    cyc(0, 0, 0, 1, "R7");
    chk("R8", "last", int'(last_o), 1);
    cyc(0, 0, 0, 1, "R7");
    chk("R9", "done", int'(done_o), 1);
    // large count
    cyc(1, 65535, 0, 0, "R2");
    cyc(0, 0, 0, 1, "R5");

    for (int i = 0; i < 4000; i++) begin
      bit ld = ($urandom_range(0, 9) == 0);
      int cnt = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 65535))
                                            : int'($urandom_range(0, 70));
      cyc(ld, cnt, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), "RND");
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk_i);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule